// File: doc/BRIEF.md
# Multi-Hash Directory Array with Tree-Walk Replacement

This block is the tag store of a coherence directory slice. It holds line entries in a small number of ways. Each way is addressed by its own universal (H3-style) hash of the line address, so a given address maps to one row in every way. A request either only looks up an address, or looks it up and inserts it on a miss. If one of the address's first-level slots is empty, the insert is written at once.

When every first-level slot is occupied, the block walks a tree of alternative homes breadth-first. It takes the address stored in each occupied candidate and rehashes it into the other ways. That gives 4 + 12 + 36 = 52 candidate slots with the default four ways. The walk stops early at the first empty slot. If the walk finds no empty slot, it picks a victim: any non-root entry beats a root entry, and the oldest age stamp wins within a class. It then moves entries one step at a time along the recorded parent path, so the new address can take a first-level slot.

Surrounding logic sees a single request port, a response pulse, a `busy` flag that holds off new requests during a replacement, and an eviction pulse. The eviction pulse carries the displaced address and its entry kind. The array storage is modelled with flops behind a read/write port.

Top module: `mhd_dir_replace`

## Requirements
- R1: After reset `busy`, `resp_valid` and `evict_valid` are low and the array holds no entries, so a first lookup of any address misses.
- R2: A request whose address is resident produces `resp_valid` with `resp_hit`=1 in the cycle after acceptance, without raising `busy`, without an eviction and without changing the array, whether `req_insert` is set or not.
- R3: A request with `req_insert`=0 whose address is absent responds with `resp_hit`=0 and inserts nothing; a later lookup of that address still misses.
- R4: An insert that finds an empty first-level slot writes it immediately, in the lowest-numbered free way. It responds with `resp_hit`=0 the next cycle, never raises `busy` and emits no eviction.
- R5: Way w indexes its rows with its own H3 hash of the address (XOR of per-way, per-bit constant rows over the set address bits, low index bits kept). Relocation moves an entry only to a slot that its own hash selects, so every inserted address either is reported evicted exactly once or still hits later.
- R6: With all first-level slots full, `busy` rises and the walk examines candidates breadth-first, one per cycle, stopping at the first empty slot. `busy` stays high for at most 55 cycles (52 candidate steps plus up to 3 writes). When no candidate is empty, it stays high for at least 53 cycles.
- R7: Victim class: kind codes 0 (limited-pointer) and 1 (leaf) are non-root; codes 2 (root) and 3 are root. A non-root entry is always chosen over a root entry.
- R8: Among entries of the same class the one with the smallest age stamp is evicted. Age stamps follow insertion order: each completed insert takes the next value, and hits do not change it.
- R9: An eviction is a single-cycle `evict_valid` pulse, issued while `busy` is high and before the response. It carries the victim's address and kind. A replacement that lands in an empty slot emits none.
- R10: A request presented while `busy` is high is ignored: it gets no response and inserts nothing.
- R11: The cycle in which `busy` falls carries the `resp_valid` pulse of the request that caused the replacement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present; accepted only while `busy` is low |
| req_addr | input | ADDR_W | Line address of the request |
| req_kind | input | 2 | Entry kind stored on insert (0 limited-pointer, 1 leaf, 2 root, 3 root) |
| req_insert | input | 1 | 1: insert on miss; 0: lookup only |
| busy | output | 1 | A replacement walk or relocation is in progress |
| resp_valid | output | 1 | One-cycle completion pulse for an accepted request |
| resp_hit | output | 1 | Address was resident when the request was accepted |
| evict_valid | output | 1 | One-cycle pulse: a resident entry was displaced |
| evict_addr | output | ADDR_W | Address of the displaced entry |
| evict_kind | output | 2 | Kind of the displaced entry |

## Verification
A one-row configuration makes the array fully associative. There the victim can be predicted from insertion order and kind alone, which covers the class-before-age rule and the all-root case. A design that compared age before class would evict a stale root entry while a leaf was resident. A design that ignored age would evict the wrong entry among roots. Requests held during a long walk must leave no trace; a design that sampled them would produce an extra response or a phantom entry that a later lookup hits. In the default configuration seventy inserts overfill sixty-four slots and force multi-step relocations. Every address must then either be reported evicted or still hit, so a wrong move order or a stale parent pointer shows up as a silently lost or duplicated line.

// File: rtl/mhd_pkg.sv
package mhd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WALK = 2'd1,
        ST_MOVE = 2'd2
    } mhd_state_e;

    localparam logic [1:0] KIND_LIMPTR = 2'd0;
    localparam logic [1:0] KIND_LEAF   = 2'd1;
    localparam logic [1:0] KIND_ROOT   = 2'd2;

    // One row of the H3 matrix for a given way and address bit.
    function automatic logic [31:0] h3_row(int way, int bit_i);
        logic [31:0] v;
        v = (32'(way + 1) * 32'h9E37_79B1) ^ (32'(bit_i + 1) * 32'h85EB_CA77);
        v = v ^ (v >> 15);
        v = v * 32'h2C1B_3C6D;
        v = v ^ (v >> 13);
        return v;
    endfunction

    // XOR of the rows selected by the set address bits.
    function automatic logic [31:0] h3_hash(int way, logic [63:0] addr, int abits);
        logic [31:0] h;
        h = '0;
        for (int b = 0; b < 64; b++) begin
            if (b < abits && addr[b]) h = h ^ h3_row(way, b);
        end
        return h;
    endfunction

endpackage

// File: rtl/mhd_hash.sv
module mhd_hash
    import mhd_pkg::*;
#(
    parameter int WAY    = 0,
    parameter int ADDR_W = 16,
    parameter int SETS   = 16,
    parameter int IDX_W  = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx
);
    logic [31:0] h;

    always_comb begin
        h   = h3_hash(WAY, 64'(addr), ADDR_W);
        idx = h[IDX_W-1:0] & IDX_W'(SETS - 1);
    end
endmodule

// File: rtl/mhd_ram.sv
module mhd_ram #(
    parameter int WAYS  = 4,
    parameter int SETS  = 16,
    parameter int IDX_W = 4,
    parameter int WW    = 2,
    parameter int ENT_W = 31
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [WAYS-1:0][IDX_W-1:0]      row_idx,
    output logic [WAYS-1:0][ENT_W-1:0]      row_data,
    input  logic [WW-1:0]                   rd_way,
    input  logic [IDX_W-1:0]                rd_idx,
    output logic [ENT_W-1:0]                rd_data,
    input  logic                            we,
    input  logic [WW-1:0]                   wr_way,
    input  logic [IDX_W-1:0]                wr_idx,
    input  logic [ENT_W-1:0]                wr_data
);
    logic [ENT_W-1:0] mem_q [WAYS][SETS];

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int s = 0; s < SETS; s++) mem_q[w][s] <= '0;
            end else if (we && wr_way == WW'(w)) begin
                mem_q[w][wr_idx] <= wr_data;
            end
        end
        assign row_data[w] = mem_q[w][row_idx[w]];
    end

    assign rd_data = mem_q[rd_way][rd_idx];
endmodule

// File: rtl/mhd_pick.sv
module mhd_pick #(
    parameter int AGE_W = 12
) (
    input  logic             cand_root,
    input  logic [AGE_W-1:0] cand_age,
    input  logic             best_ok,
    input  logic             best_root,
    input  logic [AGE_W-1:0] best_age,
    output logic             better
);
    always_comb begin
        if (!best_ok)                    better = 1'b1;
        else if (cand_root != best_root) better = !cand_root;
        else                             better = cand_age < best_age;
    end
endmodule

// File: rtl/mhd_dir_replace.sv
module mhd_dir_replace
    import mhd_pkg::*;
#(
    parameter int WAYS   = 4,
    parameter int SETS   = 16,
    parameter int ADDR_W = 16,
    parameter int AGE_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_kind,
    input  logic              req_insert,
    output logic              busy,
    output logic              resp_valid,
    output logic              resp_hit,
    output logic              evict_valid,
    output logic [ADDR_W-1:0] evict_addr,
    output logic [1:0]        evict_kind
);
    localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1;
    localparam int WW    = (WAYS > 1) ? $clog2(WAYS) : 1;
    localparam int NL1   = WAYS * (WAYS - 1);
    localparam int NEXP  = WAYS + NL1;
    localparam int NCAND = NEXP + NL1 * (WAYS - 1);
    localparam int CP_W  = $clog2(NCAND);

    typedef struct packed {
        logic              vld;
        logic [1:0]        kind;
        logic [AGE_W-1:0]  age;
        logic [ADDR_W-1:0] addr;
    } entry_t;

    localparam int ENT_W = $bits(entry_t);

    typedef struct packed {
        mhd_state_e                   st;
        logic [CP_W-1:0]              ptr;
        logic [CP_W-1:0]              cur;
        logic [CP_W-1:0]              best;
        logic                         best_ok;
        logic                         best_root;
        logic [AGE_W-1:0]             best_age;
        logic [ADDR_W-1:0]            best_addr;
        logic [1:0]                   best_kind;
        logic [NCAND-1:0][WW-1:0]     cway;
        logic [NCAND-1:0][IDX_W-1:0]  cidx;
        logic [NCAND-1:0][CP_W-1:0]   cpar;
        logic [ADDR_W-1:0]            new_addr;
        logic [1:0]                   new_kind;
        logic [AGE_W-1:0]             age_ctr;
        logic                         rv;
        logic                         rh;
        logic                         ev;
        logic [ADDR_W-1:0]            ev_addr;
        logic [1:0]                   ev_kind;
    } regs_t;

    regs_t s_q, s_d;

    // array port
    logic [WAYS-1:0][IDX_W-1:0] l1_idx;
    logic [WAYS-1:0][ENT_W-1:0] row_data;
    logic [WW-1:0]              rd_way;
    logic [IDX_W-1:0]           rd_idx;
    logic [ENT_W-1:0]           rd_data;
    logic                       we;
    logic [WW-1:0]              wr_way;
    logic [IDX_W-1:0]           wr_idx;
    logic [ENT_W-1:0]           wr_data;

    entry_t                     rd_ent;
    logic [WAYS-1:0][IDX_W-1:0] kid_idx;
    logic                       better;

    assign rd_ent = entry_t'(rd_data);

    // Per-way hash of the request address and of the candidate being expanded.
    for (genvar w = 0; w < WAYS; w++) begin : g_hash
        mhd_hash #(.WAY(w), .ADDR_W(ADDR_W), .SETS(SETS), .IDX_W(IDX_W)) u_req_hash (
            .addr (req_addr),
            .idx  (l1_idx[w])
        );
        mhd_hash #(.WAY(w), .ADDR_W(ADDR_W), .SETS(SETS), .IDX_W(IDX_W)) u_kid_hash (
            .addr (rd_ent.addr),
            .idx  (kid_idx[w])
        );
    end

    mhd_ram #(
        .WAYS(WAYS), .SETS(SETS), .IDX_W(IDX_W), .WW(WW), .ENT_W(ENT_W)
    ) u_ram (
        .clk      (clk),
        .rst_n    (rst_n),
        .row_idx  (l1_idx),
        .row_data (row_data),
        .rd_way   (rd_way),
        .rd_idx   (rd_idx),
        .rd_data  (rd_data),
        .we       (we),
        .wr_way   (wr_way),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data)
    );

    mhd_pick #(.AGE_W(AGE_W)) u_pick (
        .cand_root (rd_ent.kind[1]),
        .cand_age  (rd_ent.age),
        .best_ok   (s_q.best_ok),
        .best_root (s_q.best_root),
        .best_age  (s_q.best_age),
        .better    (better)
    );

    // First-level lookup: hit detection and lowest free way.
    logic          l1_hit;
    logic          l1_free;
    logic [WW-1:0] l1_free_way;
    entry_t        l1_ent;

    always_comb begin
        l1_hit      = 1'b0;
        l1_free     = 1'b0;
        l1_free_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            l1_ent = entry_t'(row_data[w]);
            if (l1_ent.vld && l1_ent.addr == req_addr) l1_hit = 1'b1;
            if (!l1_ent.vld && !l1_free) begin
                l1_free     = 1'b1;
                l1_free_way = WW'(w);
            end
        end
    end

    // A third-level candidate that lands on its own root slot is skipped.
    logic            is_dup;
    logic [CP_W-1:0] gpar;

    always_comb begin
        gpar   = s_q.cpar[s_q.cpar[s_q.ptr]];
        is_dup = (32'(s_q.ptr) >= NEXP) &&
                 (s_q.cway[gpar] == s_q.cway[s_q.ptr]) &&
                 (s_q.cidx[gpar] == s_q.cidx[s_q.ptr]);
    end

    entry_t new_ent;
    always_comb begin
        new_ent.vld  = 1'b1;
        new_ent.kind = s_q.new_kind;
        new_ent.age  = s_q.age_ctr;
        new_ent.addr = s_q.new_addr;
    end

    always_comb begin
        logic [WW-1:0]   cw;
        logic [CP_W-1:0] par;
        int              slot;
        entry_t          ins;

        s_d     = s_q;
        s_d.rv  = 1'b0;
        s_d.ev  = 1'b0;
        we      = 1'b0;
        wr_way  = '0;
        wr_idx  = '0;
        wr_data = '0;
        rd_way  = '0;
        rd_idx  = '0;
        cw      = '0;
        par     = '0;
        slot    = 0;
        ins.vld  = 1'b1;
        ins.kind = req_kind;
        ins.age  = s_q.age_ctr;
        ins.addr = req_addr;

        unique case (s_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    if (l1_hit || !req_insert) begin
                        s_d.rv = 1'b1;
                        s_d.rh = l1_hit;
                    end else if (l1_free) begin
                        we          = 1'b1;
                        wr_way      = l1_free_way;
                        wr_idx      = l1_idx[l1_free_way];
                        wr_data     = ins;
                        s_d.age_ctr = s_q.age_ctr + 1'b1;
                        s_d.rv      = 1'b1;
                        s_d.rh      = 1'b0;
                    end else begin
                        for (int w = 0; w < WAYS; w++) begin
                            s_d.cway[w] = WW'(w);
                            s_d.cidx[w] = l1_idx[w];
                            s_d.cpar[w] = '0;
                        end
                        s_d.ptr      = '0;
                        s_d.best_ok  = 1'b0;
                        s_d.new_addr = req_addr;
                        s_d.new_kind = req_kind;
                        s_d.st       = ST_WALK;
                    end
                end
            end

            ST_WALK: begin
                rd_way = s_q.cway[s_q.ptr];
                rd_idx = s_q.cidx[s_q.ptr];
                if (!rd_ent.vld) begin
                    s_d.cur = s_q.ptr;
                    s_d.st  = ST_MOVE;
                end else begin
                    if (!is_dup && better) begin
                        s_d.best      = s_q.ptr;
                        s_d.best_ok   = 1'b1;
                        s_d.best_root = rd_ent.kind[1];
                        s_d.best_age  = rd_ent.age;
                        s_d.best_addr = rd_ent.addr;
                        s_d.best_kind = rd_ent.kind;
                    end
                    if (32'(s_q.ptr) < NEXP) begin
                        for (int k = 0; k < WAYS - 1; k++) begin
                            cw   = (WW'(k) < s_q.cway[s_q.ptr]) ? WW'(k) : WW'(k + 1);
                            slot = WAYS + (WAYS - 1) * 32'(s_q.ptr) + k;
                            s_d.cway[slot] = cw;
                            s_d.cidx[slot] = kid_idx[cw];
                            s_d.cpar[slot] = s_q.ptr;
                        end
                    end
                    if (32'(s_q.ptr) == NCAND - 1) begin
                        s_d.cur     = s_d.best;
                        s_d.ev      = 1'b1;
                        s_d.ev_addr = s_d.best_addr;
                        s_d.ev_kind = s_d.best_kind;
                        s_d.st      = ST_MOVE;
                    end else begin
                        s_d.ptr = s_q.ptr + 1'b1;
                    end
                end
            end

            ST_MOVE: begin
                we     = 1'b1;
                wr_way = s_q.cway[s_q.cur];
                wr_idx = s_q.cidx[s_q.cur];
                if (32'(s_q.cur) < WAYS) begin
                    wr_data     = new_ent;
                    s_d.age_ctr = s_q.age_ctr + 1'b1;
                    s_d.rv      = 1'b1;
                    s_d.rh      = 1'b0;
                    s_d.st      = ST_IDLE;
                end else begin
                    par     = s_q.cpar[s_q.cur];
                    rd_way  = s_q.cway[par];
                    rd_idx  = s_q.cidx[par];
                    wr_data = rd_data;
                    s_d.cur = par;
                end
            end

            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy        = (s_q.st != ST_IDLE);
    assign resp_valid  = s_q.rv;
    assign resp_hit    = s_q.rh;
    assign evict_valid = s_q.ev;
    assign evict_addr  = s_q.ev_addr;
    assign evict_kind  = s_q.ev_kind;
endmodule

// File: rtl/mhd_dir_chk.sv
module mhd_dir_chk #(
    parameter int WAYS = 4
) (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic busy,
    input logic resp_valid,
    input logic resp_hit,
    input logic evict_valid
);
    localparam int NL1   = WAYS * (WAYS - 1);
    localparam int NCAND = WAYS + NL1 + NL1 * (WAYS - 1);
    localparam int LIMIT = NCAND + 3;

    logic [15:0] run_q;
    always_ff @(posedge clk) begin
        if (!rst_n)    run_q <= '0;
        else if (busy) run_q <= run_q + 1'b1;
        else           run_q <= '0;
    end

    AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        32'(run_q) <= LIMIT); // R6

    AST_BUSY_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid)); // R10

    AST_EVICT_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        evict_valid |-> busy); // R9

    AST_EVICT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        evict_valid |=> !evict_valid); // R9

    AST_RESP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> !busy); // R11

    AST_FALL_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> resp_valid); // R11

    AST_HIT_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_hit) |-> !$past(busy)); // R2
endmodule

bind mhd_dir_replace mhd_dir_chk #(.WAYS(WAYS)) u_mhd_dir_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .busy        (busy),
    .resp_valid  (resp_valid),
    .resp_hit    (resp_hit),
    .evict_valid (evict_valid)
);

// File: tb/test_mhd_dir_replace.sv
module test_mhd_dir_replace;
    localparam int AW = 16;

    logic clk = 1'b0;
    always #5 clk = ~clk;
    logic rst_n = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // small instance: one row per way, fully associative
    logic          a_rq = 1'b0, a_ins = 1'b0;
    logic [AW-1:0] a_addr = '0;
    logic [1:0]    a_kind = '0;
    logic          a_busy, a_rv, a_rh, a_ev;
    logic [AW-1:0] a_eva;
    logic [1:0]    a_evk;

    mhd_dir_replace #(.SETS(1)) i_mhd_dir_replace (
        .clk(clk), .rst_n(rst_n), .req_valid(a_rq), .req_addr(a_addr),
        .req_kind(a_kind), .req_insert(a_ins), .busy(a_busy), .resp_valid(a_rv),
        .resp_hit(a_rh), .evict_valid(a_ev), .evict_addr(a_eva), .evict_kind(a_evk)
    );

    // default instance
    logic          b_rq = 1'b0, b_ins = 1'b0;
    logic [AW-1:0] b_addr = '0;
    logic [1:0]    b_kind = '0;
    logic          b_busy, b_rv, b_rh, b_ev;
    logic [AW-1:0] b_eva;
    logic [1:0]    b_evk;

    mhd_dir_replace i_mhd_dir_replace_big (
        .clk(clk), .rst_n(rst_n), .req_valid(b_rq), .req_addr(b_addr),
        .req_kind(b_kind), .req_insert(b_ins), .busy(b_busy), .resp_valid(b_rv),
        .resp_hit(b_rh), .evict_valid(b_ev), .evict_addr(b_eva), .evict_kind(b_evk)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // scoreboard queues for the small instance
    int  q_resp[$];
    int  q_ev[$];
    int  a_resp_n = 0, a_bcnt = 0, a_last_busy = 0;

    always @(negedge clk) if (rst_n) begin
        if (a_busy) a_bcnt++;
        if (a_ev) begin
            if (q_ev.size() == 0) chk(1'b0, "R9", "unexpected eviction", int'({a_evk, a_eva}), 0);
            else begin
                int e;
                e = q_ev.pop_front();
                chk(int'({a_evk, a_eva}) == e, "R7", "victim kind/address", int'({a_evk, a_eva}), e);
            end
        end
        if (a_rv) begin
            if (q_resp.size() == 0) chk(1'b0, "R10", "unexpected response", int'(a_rh), 0);
            else begin
                int r;
                r = q_resp.pop_front();
                chk(int'(a_rh) == r, "R2", "hit flag", int'(a_rh), r);
            end
            a_last_busy = a_bcnt;
            a_bcnt      = 0;
            a_resp_n++;
        end
    end

    // reference model of the four-entry array
    int m_addr[4], m_kind[4], m_age[4];
    int m_n = 0, m_age_ctr = 0;

    task automatic a_do(input int addr, input int kind, input bit ins, input bit poke);
        int hit_i, v, n0;
        hit_i = -1;
        for (int i = 0; i < m_n; i++) if (m_addr[i] == addr) hit_i = i;
        if (hit_i >= 0 || !ins) q_resp.push_back(hit_i >= 0 ? 1 : 0);
        else if (m_n < 4) begin
            m_addr[m_n] = addr; m_kind[m_n] = kind; m_age[m_n] = m_age_ctr;
            m_n++; m_age_ctr++;
            q_resp.push_back(0);
        end else begin
            v = 0;
            for (int i = 1; i < 4; i++) begin
                bit ri, rv;
                ri = m_kind[i] >= 2;
                rv = m_kind[v] >= 2;
                if ((!ri && rv) || (ri == rv && m_age[i] < m_age[v])) v = i;
            end
            q_ev.push_back((m_kind[v] << AW) | m_addr[v]);
            m_addr[v] = addr; m_kind[v] = kind; m_age[v] = m_age_ctr;
            m_age_ctr++;
            q_resp.push_back(0);
        end
        @(negedge clk);
        while (a_busy) @(negedge clk);
        a_rq = 1'b1; a_addr = AW'(addr); a_kind = 2'(kind); a_ins = ins;
        n0 = a_resp_n;
        @(posedge clk);
        #1;
        if (poke) begin
            // R10: requests held while busy must leave no trace
            a_addr = 16'h7777; a_kind = 2'd1; a_ins = 1'b1;
            repeat (10) @(posedge clk);
            #1;
        end
        a_rq = 1'b0;
        while (a_resp_n == n0) @(posedge clk);
    endtask

    // default instance bookkeeping
    int b_evicted[int];
    int b_evn = 0, b_bcnt = 0, b_resp_n = 0;
    bit b_last_hit;

    always @(negedge clk) if (rst_n) begin
        if (b_busy) b_bcnt++;
        if (b_ev) begin
            chk(!b_evicted.exists(int'(b_eva)), "R5", "address evicted twice", int'(b_eva), 0);
            b_evicted[int'(b_eva)] = 1;
            b_evn++;
        end
        if (b_rv) begin
            chk(b_bcnt <= 55, "R6", "busy run length", b_bcnt, 55);
            b_bcnt     = 0;
            b_last_hit = b_rh;
            b_resp_n++;
        end
    end

    task automatic b_do(input int addr, input int kind, input bit ins, output bit hit);
        int n0;
        @(negedge clk);
        while (b_busy) @(negedge clk);
        b_rq = 1'b1; b_addr = AW'(addr); b_kind = 2'(kind); b_ins = ins;
        n0 = b_resp_n;
        @(posedge clk);
        #1;
        b_rq = 1'b0;
        while (b_resp_n == n0) @(posedge clk);
        hit = b_last_hit;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "R6", "watchdog expired", 0, 1);
        finish_run();
    end

    localparam int KA = 16'h00A1, KB = 16'h00B2, KC = 16'h00C3, KD = 16'h00D4;
    localparam int KE = 16'h00E5, KF = 16'h00F6, KG = 16'h0107, KH = 16'h0118;

    initial begin
        bit h;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!a_busy && !a_rv && !a_ev, "R1", "outputs after reset", int'({a_busy, a_rv, a_ev}), 0);
        chk(!b_busy && !b_rv && !b_ev, "R1", "outputs after reset (big)", int'({b_busy, b_rv, b_ev}), 0);

        // R1/R3 lookup-only misses insert nothing
        a_do(KA, 1, 1'b0, 1'b0);
        a_do(KA, 1, 1'b0, 1'b0);

        // R4 fill first-level slots directly
        a_do(KA, 1, 1'b1, 1'b0);
        chk(a_last_busy == 0, "R4", "busy on free-slot insert", a_last_busy, 0);
        a_do(KB, 2, 1'b1, 1'b0);
        a_do(KC, 0, 1'b1, 1'b0);
        a_do(KD, 2, 1'b1, 1'b0);
        chk(a_last_busy == 0, "R4", "busy on last free slot", a_last_busy, 0);

        // R2 hits, with and without insert
        a_do(KB, 2, 1'b0, 1'b0);
        a_do(KA, 1, 1'b1, 1'b0);
        chk(a_last_busy == 0, "R2", "busy on hit", a_last_busy, 0);

        // R6/R7/R8 full: leaf A (oldest non-root) goes; R10 poke while busy
        a_do(KE, 2, 1'b1, 1'b1);
        chk(a_last_busy >= 53 && a_last_busy <= 55, "R6", "full-walk busy length", a_last_busy, 53);
        a_do(16'h7777, 1, 1'b0, 1'b0);   // R10: must miss

        // R7: only non-root entry is the limited-pointer C
        a_do(KF, 1, 1'b1, 1'b0);
        // R7: leaf F goes before older roots
        a_do(KG, 2, 1'b1, 1'b0);
        // R8: all root, oldest B goes
        a_do(KH, 3, 1'b1, 1'b0);
        a_do(KB, 2, 1'b0, 1'b0);
        a_do(KD, 2, 1'b0, 1'b0);
        a_do(KH, 3, 1'b0, 1'b0);
        chk(q_resp.size() == 0 && q_ev.size() == 0, "R9", "scoreboard drained",
            q_resp.size() + q_ev.size(), 0);

        // R5 integrity under relocation on the default instance
        for (int i = 0; i < 70; i++) begin
            b_do(16'h0100 + i * 53, i % 4, 1'b1, h);
            chk(!h, "R4", "new address reported hit", int'(h), 0);
        end
        chk(b_evn >= 6, "R5", "evictions after overfill", b_evn, 6);
        for (int i = 0; i < 70; i++) begin
            int a;
            a = 16'h0100 + i * 53;
            b_do(a, 0, 1'b0, h);
            chk(h == !b_evicted.exists(a), "R5", "resident or evicted", int'(h),
                int'(!b_evicted.exists(a)));
        end
        repeat (5) @(posedge clk);
        finish_run();
    end
endmodule